// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the integer register file of a small 32-bit RISC core. The core names sixteen architectural registers with 4-bit numbers. Their physical location depends on a mode input. Names 0 through 12 refer to one shared set of registers. Names 13 (stack pointer) and 14 (return address) each have a separate copy in every mode. Name 15 is not stored in the pool: it is the program counter. The file has two combinational read ports and one clocked write port.

A current status word is shared by every mode. Each privileged mode also has its own saved status word. A mode-entry strobe copies the current status into the saved word of the new mode. A return strobe copies the active saved word back into the current status. The core sets the mode input to the target mode in the same cycle as an entry strobe.

Top module: `banked_regfile`

## Requirements
- R1: After an asynchronous active-low reset, every general register in every mode reads zero, register 15 reads 8 (program counter 0), the current status reads zero and every saved status reads zero.
- R2: Names 0 to 12 map to one physical register each, whatever the mode. A value written in one mode reads back unchanged in all four modes.
- R3: Names 13 and 14 have a separate copy in each mode. Mode code 0 is user, and codes 1, 2 and 3 are privileged. A write in one mode changes only that mode's copy.
- R4: Both read ports are combinational. Each port returns the value of the register it selects in the same cycle that the index or mode is applied, and the two ports work independently.
- R5: A write lands at the clock edge. A read of the same register in the write cycle returns the old value, and the new value appears from the next cycle on. Nothing is forwarded.
- R6: A read of name 15 returns the program counter plus 8. The program counter resets to 0, and the step input adds 4 to it at each clock edge.
- R7: A write to name 15 loads the program counter with the write data and takes precedence over a step in the same cycle. No pool register changes.
- R8: The status write enable loads the current status with the write data at the next edge, whatever the mode. One status word is shared by all modes.
- R9: The saved status output shows the saved word of the active mode. The saved write enable writes that word. In user mode the output is zero and a saved write has no effect.
- R10: An entry strobe in a privileged mode copies the current status into that mode's saved word. If the same cycle also carries a status write, the saved word gets the old status and the current status gets the new data. The entry strobe takes precedence over a saved write.
- R11: A return strobe in a privileged mode loads the current status from the active saved word. It takes precedence over a status write. A return in user mode, or together with an entry strobe, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | Active mode: 0 user, 1..3 privileged |
| rd_a_idx | input | 4 | Read port A register name |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B register name |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Register write name |
| wr_data | input | 32 | Register write data |
| pc_step | input | 1 | Advance program counter by 4 |
| status_wr_en | input | 1 | Current status write enable |
| status_wr_data | input | 32 | Current status write data |
| status_q | output | 32 | Current status |
| saved_wr_en | input | 1 | Saved status write enable (active mode) |
| saved_wr_data | input | 32 | Saved status write data |
| saved_q | output | 32 | Saved status of active mode, zero in user |
| enter_en | input | 1 | Mode-entry strobe |
| ret_en | input | 1 | Return strobe |

## Verification
The case that needs care is a mode entry and a status write in the same cycle. Two status registers then change at one edge, and each must take the correct side of that edge. The bench raises the entry strobe and the status write together in a privileged mode. In the next cycle it expects the saved word to hold the status from before the edge and the current status to hold the new data. The same approach covers a return combined with a status write, where the return must win, and a register write combined with a read of the same register, where the read must return the old value. Every case is compared cycle by cycle against a behavioural model.

// File: rtl/rf_pkg.sv
`timescale 1ns/1ps
package rf_pkg;
  localparam int unsigned PC_STEP_BYTES  = 4;
  localparam int unsigned PC_AHEAD_BYTES = 8;
  localparam int unsigned USER_MODE      = 0;

  function automatic logic [31:0] pc_advance(input logic [31:0] pc);
    return pc + 32'(PC_STEP_BYTES);
  endfunction

  function automatic logic [31:0] pc_view(input logic [31:0] pc);
    return pc + 32'(PC_AHEAD_BYTES);
  endfunction
endpackage

// File: rtl/rf_name_map.sv
`timescale 1ns/1ps
module rf_name_map #(
  parameter int IW = 4,
  parameter int MW = 2,
  parameter int PW = 5,
  parameter int FIRST_BANKED = 13
) (
  input  logic [IW-1:0] idx,
  input  logic [MW-1:0] mode,
  output logic [PW-1:0] phys,
  output logic          is_pc
);
  localparam int PC_IDX = (1 << IW) - 1;
  localparam int NB     = PC_IDX - FIRST_BANKED;

  function automatic logic [PW-1:0] banked_slot(input logic [IW-1:0] i,
                                                input logic [MW-1:0] m);
    return PW'(FIRST_BANKED + NB * int'(m) + (int'(i) - FIRST_BANKED));
  endfunction

  always_comb begin
    is_pc = (idx == IW'(PC_IDX));
    if (is_pc)
      phys = '0;
    else if (int'(idx) < FIRST_BANKED)
      phys = PW'(idx);
    else
      phys = banked_slot(idx, mode);
  end
endmodule

// File: rtl/rf_gpr_pool.sv
`timescale 1ns/1ps
module rf_gpr_pool #(
  parameter int DW = 32,
  parameter int PW = 5,
  parameter int NPHYS = 21,
  parameter int NRD = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [PW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [PW-1:0] raddr [NRD],
  output logic [DW-1:0] rdata [NRD]
);
  localparam int SLOTS = 1 << PW;

  logic [DW-1:0] regs [SLOTS];

  for (genvar r = 0; r < SLOTS; r++) begin : g_slot
    if (r < NPHYS) begin : g_live
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          regs[r] <= '0;
        else if (we && waddr == PW'(r))
          regs[r] <= wdata;
      end
    end else begin : g_void
      assign regs[r] = '0;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = regs[raddr[p]];
  end
endmodule

// File: rtl/rf_status_bank.sv
`timescale 1ns/1ps
module rf_status_bank #(
  parameter int DW = 32,
  parameter int MW = 2,
  parameter int NPRIV = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [MW-1:0] mode,
  input  logic          status_wr_en,
  input  logic [DW-1:0] status_wr_data,
  input  logic          saved_wr_en,
  input  logic [DW-1:0] saved_wr_data,
  input  logic          enter_take,
  input  logic          ret_take,
  output logic [DW-1:0] status_q,
  output logic [DW-1:0] saved_q
);
  localparam int SLOTS = 1 << MW;

  logic [DW-1:0] saved_r [SLOTS];

  for (genvar m = 0; m < SLOTS; m++) begin : g_saved
    if (m >= 1 && m <= NPRIV) begin : g_priv
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          saved_r[m] <= '0;
        else if (mode == MW'(m)) begin
          if (enter_take)
            saved_r[m] <= status_q;
          else if (saved_wr_en)
            saved_r[m] <= saved_wr_data;
        end
      end
    end else begin : g_none
      assign saved_r[m] = '0;
    end
  end

  assign saved_q = saved_r[mode];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      status_q <= '0;
    else if (ret_take)
      status_q <= saved_q;
    else if (status_wr_en)
      status_q <= status_wr_data;
  end
endmodule

// File: rtl/rf_pc.sv
`timescale 1ns/1ps
module rf_pc #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          step,
  output logic [DW-1:0] pc_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pc_q <= '0;
    else if (load)
      pc_q <= load_val;
    else if (step)
      pc_q <= rf_pkg::pc_advance(pc_q);
  end
endmodule

// File: rtl/banked_regfile.sv
`timescale 1ns/1ps
module banked_regfile #(
  parameter int DW = 32,
  parameter int IW = 4,
  parameter int MW = 2,
  parameter int NPRIV = 3,
  parameter int FIRST_BANKED = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [MW-1:0] mode,
  input  logic [IW-1:0] rd_a_idx,
  output logic [DW-1:0] rd_a_data,
  input  logic [IW-1:0] rd_b_idx,
  output logic [DW-1:0] rd_b_data,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          pc_step,
  input  logic          status_wr_en,
  input  logic [DW-1:0] status_wr_data,
  output logic [DW-1:0] status_q,
  input  logic          saved_wr_en,
  input  logic [DW-1:0] saved_wr_data,
  output logic [DW-1:0] saved_q,
  input  logic          enter_en,
  input  logic          ret_en
);
  localparam int PC_IDX = (1 << IW) - 1;
  localparam int NB     = PC_IDX - FIRST_BANKED;
  localparam int NPHYS  = FIRST_BANKED + NB * (NPRIV + 1);
  localparam int PW     = $clog2(NPHYS);
  localparam int NPORT  = 3;
  localparam int NRD    = 2;

  logic [IW-1:0] map_idx  [NPORT];
  logic [PW-1:0] map_phys [NPORT];
  logic          map_pc   [NPORT];

  assign map_idx[0] = rd_a_idx;
  assign map_idx[1] = rd_b_idx;
  assign map_idx[2] = wr_idx;

  for (genvar p = 0; p < NPORT; p++) begin : g_map
    rf_name_map #(.IW(IW), .MW(MW), .PW(PW), .FIRST_BANKED(FIRST_BANKED)) u_map (
      .idx  (map_idx[p]),
      .mode (mode),
      .phys (map_phys[p]),
      .is_pc(map_pc[p])
    );
  end

  logic          priv_mode;
  logic          enter_take;
  logic          ret_take;
  logic          pool_we;
  logic          pc_load;
  logic [DW-1:0] pc_q;
  logic [PW-1:0] pool_raddr [NRD];
  logic [DW-1:0] pool_rdata [NRD];

  assign priv_mode  = (mode != MW'(rf_pkg::USER_MODE)) && (int'(mode) <= NPRIV);
  assign enter_take = enter_en && priv_mode;
  assign ret_take   = ret_en && priv_mode && !enter_en;
  assign pool_we    = wr_en && !map_pc[2];
  assign pc_load    = wr_en && map_pc[2];

  for (genvar p = 0; p < NRD; p++) begin : g_raddr
    assign pool_raddr[p] = map_phys[p];
  end

  rf_gpr_pool #(.DW(DW), .PW(PW), .NPHYS(NPHYS), .NRD(NRD)) u_pool (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (pool_we),
    .waddr(map_phys[2]),
    .wdata(wr_data),
    .raddr(pool_raddr),
    .rdata(pool_rdata)
  );

  rf_pc #(.DW(DW)) u_pc (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (pc_load),
    .load_val(wr_data),
    .step    (pc_step),
    .pc_q    (pc_q)
  );

  rf_status_bank #(.DW(DW), .MW(MW), .NPRIV(NPRIV)) u_status (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode          (mode),
    .status_wr_en  (status_wr_en),
    .status_wr_data(status_wr_data),
    .saved_wr_en   (saved_wr_en),
    .saved_wr_data (saved_wr_data),
    .enter_take    (enter_take),
    .ret_take      (ret_take),
    .status_q      (status_q),
    .saved_q       (saved_q)
  );

  assign rd_a_data = map_pc[0] ? rf_pkg::pc_view(pc_q) : pool_rdata[0];
  assign rd_b_data = map_pc[1] ? rf_pkg::pc_view(pc_q) : pool_rdata[1];
endmodule

// File: rtl/banked_regfile_chk.sv
`timescale 1ns/1ps
module banked_regfile_chk #(
  parameter int DW = 32,
  parameter int IW = 4,
  parameter int MW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [MW-1:0] mode,
  input logic [IW-1:0] rd_a_idx,
  input logic [DW-1:0] rd_a_data,
  input logic          wr_en,
  input logic [IW-1:0] wr_idx,
  input logic [DW-1:0] wr_data,
  input logic          pc_step,
  input logic          status_wr_en,
  input logic [DW-1:0] status_wr_data,
  input logic [DW-1:0] status_q,
  input logic [DW-1:0] saved_q,
  input logic          enter_en,
  input logic          ret_en,
  input logic [DW-1:0] pc_q
);
  localparam logic [IW-1:0] PC_NAME = '1;

  // R6
  pc_read_ahead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_a_idx == PC_NAME |-> rd_a_data == pc_q + DW'(8));

  // R6
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_step && !(wr_en && wr_idx == PC_NAME) |=> pc_q == $past(pc_q) + DW'(4));

  // R7
  pc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_idx == PC_NAME |=> pc_q == $past(wr_data));

  // R9
  user_saved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode == '0 |-> saved_q == '0);

  // R10
  enter_saves_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enter_en && mode != '0 |=> (mode != $past(mode)) || (saved_q == $past(status_q)));

  // R10
  enter_status_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enter_en && status_wr_en |=> status_q == $past(status_wr_data));

  // R11
  return_restores_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_en && !enter_en && mode != '0 |=> status_q == $past(saved_q));

  // R11
  user_return_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_en && mode == '0 && !status_wr_en |=> $stable(status_q));
endmodule

bind banked_regfile banked_regfile_chk #(.DW(DW), .IW(IW), .MW(MW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mode          (mode),
  .rd_a_idx      (rd_a_idx),
  .rd_a_data     (rd_a_data),
  .wr_en         (wr_en),
  .wr_idx        (wr_idx),
  .wr_data       (wr_data),
  .pc_step       (pc_step),
  .status_wr_en  (status_wr_en),
  .status_wr_data(status_wr_data),
  .status_q      (status_q),
  .saved_q       (saved_q),
  .enter_en      (enter_en),
  .ret_en        (ret_en),
  .pc_q          (pc_q)
);

// File: tb/banked_regfile_tb.sv
`timescale 1ns/1ps
module banked_regfile_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = '0;
  logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [31:0] rd_a_data, rd_b_data, status_q, saved_q;
  logic        wr_en = 0, pc_step = 0, status_wr_en = 0, saved_wr_en = 0;
  logic        enter_en = 0, ret_en = 0;
  logic [31:0] wr_data = '0, status_wr_data = '0, saved_wr_data = '0;

  always #2 clk = ~clk;

  banked_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .pc_step(pc_step),
    .status_wr_en(status_wr_en), .status_wr_data(status_wr_data), .status_q(status_q),
    .saved_wr_en(saved_wr_en), .saved_wr_data(saved_wr_data), .saved_q(saved_q),
    .enter_en(enter_en), .ret_en(ret_en)
  );

  // Behavioural reference model
  logic [31:0] m_shared [13];
  logic [31:0] m_stack  [4];
  logic [31:0] m_link   [4];
  logic [31:0] m_pc, m_status;
  logic [31:0] m_saved  [4];

  int    n_checks = 0, n_fail = 0;
  string cur_tag = "R1";
  bit    reported = 0;

  function automatic logic [31:0] model_read(int md, int idx);
    if (idx == 15) return m_pc + 32'd8;
    if (idx == 13) return m_stack[md];
    if (idx == 14) return m_link[md];
    return m_shared[idx];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 13; i++) m_shared[i] = '0;
      for (int i = 0; i < 4; i++) begin
        m_stack[i] = '0; m_link[i] = '0; m_saved[i] = '0;
      end
      m_pc = '0; m_status = '0;
    end else begin
      int md;
      logic [31:0] old_status, old_saved;
      md = int'(mode);
      old_status = m_status;
      old_saved  = m_saved[md];
      if (wr_en) begin
        if (wr_idx == 4'd15) m_pc = wr_data;
        else if (wr_idx == 4'd13) m_stack[md] = wr_data;
        else if (wr_idx == 4'd14) m_link[md] = wr_data;
        else m_shared[wr_idx] = wr_data;
      end
      if (pc_step && !(wr_en && wr_idx == 4'd15)) m_pc = m_pc + 32'd4;
      if (md != 0 && enter_en) begin
        m_saved[md] = old_status;
        if (status_wr_en) m_status = status_wr_data;
      end else if (md != 0 && ret_en) begin
        m_status = old_saved;
        if (saved_wr_en) m_saved[md] = saved_wr_data;
      end else begin
        if (status_wr_en) m_status = status_wr_data;
        if (md != 0 && saved_wr_en) m_saved[md] = saved_wr_data;
      end
    end
  end

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", cur_tag, what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    end
  endtask

  // inputs are set just after a negedge; compare, then wait to next negedge
  task automatic tick();
    #1;
    chk("port A", rd_a_data, model_read(int'(mode), int'(rd_a_idx)));
    chk("port B", rd_b_data, model_read(int'(mode), int'(rd_b_idx)));
    chk("status", status_q, m_status);
    chk("saved", saved_q, m_saved[mode]);
    @(negedge clk); #1;
  endtask

  task automatic idle();
    wr_en = 0; pc_step = 0; status_wr_en = 0; saved_wr_en = 0;
    enter_en = 0; ret_en = 0;
  endtask

  task automatic wr(int md, int idx, logic [31:0] d);
    mode = 2'(md); wr_en = 1; wr_idx = 4'(idx); wr_data = d;
    tick(); wr_en = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    report();
    $finish;
  end

  initial begin
    // R1: reset values, during and after reset
    @(negedge clk); #1;
    for (int i = 0; i < 16; i++) begin
      mode = 2'(i % 4); rd_a_idx = 4'(i); rd_b_idx = 4'(15 - i); tick();
    end
    rst_n = 1;
    for (int i = 0; i < 16; i++) begin
      mode = 2'((i + 1) % 4); rd_a_idx = 4'(i); rd_b_idx = 4'(15 - i); tick();
    end

    cur_tag = "R2";
    for (int i = 0; i < 13; i++) wr(i % 4, i, 32'h1000_0000 + 32'(i) * 32'h111);
    for (int md = 0; md < 4; md++)
      for (int i = 0; i < 13; i++) begin
        mode = 2'(md); rd_a_idx = 4'(i); rd_b_idx = 4'(12 - i); tick();
      end

    cur_tag = "R3";
    for (int md = 0; md < 4; md++) begin
      wr(md, 13, 32'h5100_0000 + 32'(md));
      wr(md, 14, 32'h1400_0000 + 32'(md));
    end
    for (int md = 0; md < 4; md++) begin
      mode = 2'(md); rd_a_idx = 4'd13; rd_b_idx = 4'd14; tick();
    end

    cur_tag = "R5";
    mode = 2'd2; rd_a_idx = 4'd5; rd_b_idx = 4'd13;
    wr_en = 1; wr_idx = 4'd5; wr_data = 32'hCAFE_0005; tick();
    wr_idx = 4'd13; wr_data = 32'hCAFE_0013; tick();
    wr_en = 0; tick();

    cur_tag = "R6";
    rd_a_idx = 4'd15; rd_b_idx = 4'd15; pc_step = 1;
    repeat (5) tick();
    pc_step = 0; tick();

    cur_tag = "R7";
    pc_step = 1; wr_en = 1; wr_idx = 4'd15; wr_data = 32'h0000_8000; tick();
    wr_en = 0; tick();
    pc_step = 0; rd_b_idx = 4'd0; tick();

    cur_tag = "R8";
    for (int md = 0; md < 4; md++) begin
      mode = 2'(md); status_wr_en = 1; status_wr_data = 32'hA0 + 32'(md); tick();
    end
    status_wr_en = 0; tick();

    cur_tag = "R9";
    for (int md = 1; md < 4; md++) begin
      mode = 2'(md); saved_wr_en = 1; saved_wr_data = 32'h5A00 + 32'(md); tick();
    end
    mode = 2'd0; saved_wr_data = 32'hDEAD; tick();
    saved_wr_en = 0;
    for (int md = 0; md < 4; md++) begin mode = 2'(md); tick(); end

    cur_tag = "R10";
    mode = 2'd3; status_wr_en = 1; status_wr_data = 32'h0000_00D3; tick();
    status_wr_en = 1; status_wr_data = 32'h0000_0F13; enter_en = 1; saved_wr_en = 1;
    saved_wr_data = 32'h7777; tick();
    idle(); tick();

    cur_tag = "R11";
    mode = 2'd3; status_wr_en = 1; status_wr_data = 32'h0000_0444; tick();
    ret_en = 1; status_wr_en = 1; status_wr_data = 32'h0000_0999; tick();
    idle(); tick();
    mode = 2'd0; ret_en = 1; tick();
    idle(); tick();
    mode = 2'd1; enter_en = 1; ret_en = 1; tick();
    idle(); tick();

    cur_tag = "R4";
    for (int n = 0; n < 400; n++) begin
      mode = 2'($urandom_range(0, 3));
      rd_a_idx = 4'($urandom_range(0, 15)); rd_b_idx = 4'($urandom_range(0, 15));
      wr_en = 1'($urandom_range(0, 1)); wr_idx = 4'($urandom_range(0, 15));
      wr_data = $urandom(); pc_step = 1'($urandom_range(0, 1));
      status_wr_en = 1'($urandom_range(0, 1)); status_wr_data = $urandom();
      saved_wr_en = 1'($urandom_range(0, 1)); saved_wr_data = $urandom();
      enter_en = ($urandom_range(0, 7) == 0); ret_en = ($urandom_range(0, 7) == 0);
      tick();
    end
    idle(); tick();

    report();
    $finish;
  end
endmodule